// File: doc/BRIEF.md
# Watchdog Timer with Byte Control Register

This block counts tick-enable pulses while software has the watchdog switched on. Software must restart the count before it reaches a parameterised limit. When the count does reach the limit, the block sets a time-out flag. The flag stays set until software clears it.

The flag can have two effects, and each one has its own enable bit. The first is a local reset pulse of a parameterised length, issued at the moment of the time-out. The second is a board-failure level that stays asserted for as long as the flag is set.

Control goes through one 8-bit register with a write strobe and a combinational read. Restarting the counter and clearing the flag are separate command bits that act when written with a one and read back as zero. The time-out period is fixed at build time by `TIMEOUT_TICKS`. The reset pulse length is set by `RST_PULSE_LEN`.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `regRdData` reads 0x00, and `localRstOut` and `boardFailOut` are both low.
- R2: The register layout is: bit 0 is the watchdog enable, bit 1 is the reset enable and bit 3 is the board-fail enable. These three are read/write. Bits 2, 5, 6 and 7 always read 0, so writing 0xFF to the idle block reads back 0x0B.
- R3: Bit 4 is the time-out flag and is read-only. Writing a one to it never sets it.
- R4: With the watchdog enabled, the flag reads 1 right after the clock edge that samples the `TIMEOUT_TICKS`-th tick pulse since the last restart. It reads 0 before that edge.
- R5: While bit 0 is 0, ticks do not advance the count and no time-out occurs. The count reached so far is kept and resumes when the watchdog is enabled again.
- R6: Writing a one to bit 5 sets the count back to zero. A write with bit 5 at 0 leaves the count unchanged.
- R7: Once set, the flag stays set until a write with bit 6 at 1. A write with bit 6 at 0 leaves it set. If a clear write and a time-out fall in the same cycle, the flag ends up set.
- R8: When bit 1 is set at the time-out edge, `localRstOut` is high for exactly `RST_PULSE_LEN` cycles starting at that edge. When bit 1 is 0, `localRstOut` stays low.
- R9: `boardFailOut` is high exactly while both the flag and bit 3 are 1. It follows writes to bit 3 in the same cycle.
- R10: If a restart write lands in the same cycle as the terminal tick, the restart wins. No time-out is recorded, and the next time-out needs a full `TIMEOUT_TICKS` ticks.
- R11: After a time-out the counter holds at its limit. Further ticks raise no new flag event and no new reset pulse until a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count pulse, one tick per cycle while high |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| localRstOut | output | 1 | Local reset pulse on time-out |
| boardFailOut | output | 1 | Board-failure level while the flag is set and enabled |

## Verification
The count itself is never visible at the ports. A wrong count shows up only as a flag that rises one or more ticks early or late, so the bench steps the ticks one at a time and checks the flag at every intermediate count. A pause or restart that loses or keeps counter state shows up within one time-out period, which is why restarts and disables are swept at every possible position in the count. A reset pulse of the wrong length is visible within `RST_PULSE_LEN` cycles. A flag that is not sticky, or not held at the limit, is caught by extra ticks given after the time-out.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Bit positions inside the control byte
  localparam int BIT_EN    = 0;
  localparam int BIT_RSTEN = 1;
  localparam int BIT_BFEN  = 3;
  localparam int BIT_STS   = 4;
  localparam int BIT_CCLR  = 5;
  localparam int BIT_SCLR  = 6;

  // Control-to-datapath strobes
  typedef struct packed {
    logic cntRestart;
    logic runEn;
    logic pulseArm;
  } wdStrobes_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       timeoutHit,
  output wdStrobes_t strobes,
  output logic [7:0] regRdData,
  output logic       boardFailOut
);
  logic enQ, rstEnQ, bfEnQ, stsQ;
  logic stsClrReq;

  assign stsClrReq = regWrEn & regWrData[BIT_SCLR];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      rstEnQ <= 1'b0;
      bfEnQ  <= 1'b0;
      stsQ   <= 1'b0;
    end else begin
      if (regWrEn) begin
        enQ    <= regWrData[BIT_EN];
        rstEnQ <= regWrData[BIT_RSTEN];
        bfEnQ  <= regWrData[BIT_BFEN];
      end
      // a new event beats a clear in the same cycle
      if (timeoutHit)     stsQ <= 1'b1;
      else if (stsClrReq) stsQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.cntRestart = regWrEn & regWrData[BIT_CCLR];
    strobes.runEn      = enQ;
    strobes.pulseArm   = rstEnQ;
  end

  always_comb begin
    regRdData            = '0;
    regRdData[BIT_EN]    = enQ;
    regRdData[BIT_RSTEN] = rstEnQ;
    regRdData[BIT_BFEN]  = bfEnQ;
    regRdData[BIT_STS]   = stsQ;
  end

  assign boardFailOut = stsQ & bfEnQ;

  // R4: a time-out event is recorded in the flag
  p_hit_sets_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> stsQ);
  // R7: flag is sticky without a clear request
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stsQ && !stsClrReq) |=> stsQ);
  // R7: a clear with no concurrent event empties the flag
  p_flag_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stsClrReq && !timeoutHit) |=> !stsQ);
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 50000,
  parameter int RST_PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  wdStrobes_t strobes,
  output logic       timeoutHit,
  output logic       localRstOut
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam int PW = $clog2(RST_PULSE_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST  = CW'(TIMEOUT_TICKS - 1);
  localparam logic [CW-1:0] CNT_LIMIT = CW'(TIMEOUT_TICKS);
  localparam logic [PW-1:0] PULSE_INIT = PW'(RST_PULSE_LEN);

  logic [CW-1:0] cntQ;
  logic [PW-1:0] pulseQ;
  logic          expired;
  logic          advance;

  assign expired    = (cntQ == CNT_LIMIT);
  assign advance    = strobes.runEn & tickEn & ~expired;
  assign timeoutHit = strobes.runEn & tickEn & ~strobes.cntRestart & (cntQ == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)                   cntQ <= '0;
    else if (strobes.cntRestart) cntQ <= '0;
    else if (advance)            cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                pulseQ <= '0;
    else if (timeoutHit && strobes.pulseArm)  pulseQ <= PULSE_INIT;
    else if (pulseQ != '0)                    pulseQ <= pulseQ - 1'b1;
  end

  assign localRstOut = (pulseQ != '0);

  // R6: restart zeroes the count
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntRestart |=> (cntQ == '0));
  // R5: disabled counter does not move
  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.runEn && !strobes.cntRestart) |=> $stable(cntQ));
  // R11: expired counter holds until restart
  p_hold_limit_r11: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !strobes.cntRestart) |=> expired);
  // R8: no reset pulse starts without an armed event
  p_no_stray_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ == '0 && !(timeoutHit && strobes.pulseArm)) |=> !localRstOut);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 50000,
  parameter int RST_PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       localRstOut,
  output logic       boardFailOut
);
  wdStrobes_t strobes;
  logic       timeoutHit;

  wdog_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .timeoutHit   (timeoutHit),
    .strobes      (strobes),
    .regRdData    (regRdData),
    .boardFailOut (boardFailOut)
  );

  wdog_datapath #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .RST_PULSE_LEN (RST_PULSE_LEN)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .strobes     (strobes),
    .timeoutHit  (timeoutHit),
    .localRstOut (localRstOut)
  );

  // R9: board-fail level only with the flag set
  p_bf_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    boardFailOut |-> regRdData[BIT_STS]);
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int N = 5;
  localparam int L = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       localRstOut, boardFailOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wdog_timer #(.TIMEOUT_TICKS(N), .RST_PULSE_LEN(L)) i_wdog_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .localRstOut(localRstOut), .boardFailOut(boardFailOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle; inputs removed 1 ns after the edge, outputs then stable
  task automatic step(input logic t, input logic we, input logic [7:0] d);
    tickEn = t; regWrEn = we; regWrData = d;
    @(posedge clk);
    #1;
    tickEn = 1'b0; regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00);
  endtask

  function automatic logic [7:0] cfg(input bit en, input bit re, input bit bf);
    return {4'b0000, bf, 1'b0, re, en};
  endfunction

  localparam logic [7:0] RESTART = 8'h20;
  localparam logic [7:0] SCLEAR  = 8'h40;

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1
    chk("R1 read after reset", regRdData, 0);
    chk("R1 localRstOut after reset", localRstOut, 0);
    chk("R1 boardFailOut after reset", boardFailOut, 0);

    // R2 / R3: layout, constant-zero bits, read-only flag
    step(1'b0, 1'b1, 8'hFF);
    chk("R2 R3 read of 0xFF write", regRdData, 8'h0B);
    step(1'b0, 1'b1, 8'h10);
    chk("R3 flag not writable", regRdData, 8'h00);

    // R4 R8 R9 R11 R7: sweep of reset-enable and board-fail-enable
    for (int c = 0; c < 4; c++) begin
      bit re = c[0];
      bit bf = c[1];
      step(1'b0, 1'b1, cfg(1, re, bf) | RESTART);
      for (int k = 1; k <= N; k++) begin
        step(1'b1, 1'b0, 8'h00);
        chk("R4 flag vs tick count", regRdData[4], int'(k == N));
        chk("R8 pulse at time-out", localRstOut, int'(k == N && re));
        chk("R9 board-fail level", boardFailOut, int'(k == N && bf));
      end
      for (int j = 1; j < L; j++) begin
        step(1'b0, 1'b0, 8'h00);
        chk("R8 pulse length", localRstOut, int'(re));
      end
      step(1'b0, 1'b0, 8'h00);
      chk("R8 pulse ends", localRstOut, 0);
      ticks(2 * N);
      chk("R11 no new pulse after expiry", localRstOut, 0);
      chk("R11 flag held after expiry", regRdData[4], 1);
      step(1'b0, 1'b1, cfg(1, re, bf));
      chk("R7 write with bit6 low keeps flag", regRdData[4], 1);
      step(1'b0, 1'b1, cfg(1, re, bf) | SCLEAR);
      chk("R7 flag cleared", regRdData[4], 0);
      chk("R9 board-fail drops with flag", boardFailOut, 0);
    end

    // R5: pause at every count position
    for (int p = 0; p < N; p++) begin
      step(1'b0, 1'b1, cfg(1, 0, 0) | RESTART);
      ticks(p);
      step(1'b0, 1'b1, cfg(0, 0, 0));
      ticks(2 * N);
      chk("R5 no time-out while disabled", regRdData[4], 0);
      step(1'b0, 1'b1, cfg(1, 0, 0));
      ticks(N - p - 1);
      chk("R5 count kept across pause", regRdData[4], 0);
      ticks(1);
      chk("R5 resumes at kept count", regRdData[4], 1);
      step(1'b0, 1'b1, cfg(1, 0, 0) | SCLEAR);
    end

    // R6: restart at every position; a write with bit5 low does not restart
    for (int p = 1; p < N; p++) begin
      step(1'b0, 1'b1, cfg(1, 0, 0) | RESTART);
      ticks(p);
      step(1'b0, 1'b1, cfg(1, 0, 0) | RESTART);
      ticks(N - 1);
      chk("R6 restart resets count", regRdData[4], 0);
      ticks(1);
      chk("R6 time-out after full period", regRdData[4], 1);
      step(1'b0, 1'b1, cfg(1, 0, 0) | SCLEAR);
    end
    step(1'b0, 1'b1, cfg(1, 0, 0) | RESTART);
    ticks(N - 1);
    step(1'b0, 1'b1, cfg(1, 0, 0));
    ticks(1);
    chk("R6 bit5 low does not restart", regRdData[4], 1);
    step(1'b0, 1'b1, cfg(1, 0, 0) | SCLEAR);

    // R10: restart and terminal tick together
    step(1'b0, 1'b1, cfg(1, 1, 0) | RESTART);
    ticks(N - 1);
    step(1'b1, 1'b1, cfg(1, 1, 0) | RESTART);
    chk("R10 restart wins over terminal tick", regRdData[4], 0);
    chk("R10 no pulse when restart wins", localRstOut, 0);
    ticks(N - 1);
    chk("R10 full period needed", regRdData[4], 0);
    ticks(1);
    chk("R10 later time-out", regRdData[4], 1);
    step(1'b0, 1'b1, cfg(1, 0, 0) | SCLEAR);

    // R7: clear and time-out in one cycle
    step(1'b0, 1'b1, cfg(1, 0, 0) | RESTART);
    ticks(N - 1);
    step(1'b1, 1'b1, cfg(1, 0, 0) | SCLEAR);
    chk("R7 event beats clear", regRdData[4], 1);

    // R9: board-fail follows its enable while the flag is set
    step(1'b0, 1'b1, cfg(1, 0, 1));
    chk("R9 enable raises board-fail", boardFailOut, 1);
    step(1'b0, 1'b1, cfg(1, 0, 0));
    chk("R9 disable drops board-fail", boardFailOut, 0);
    chk("R9 flag unaffected", regRdData[4], 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule